// File: doc/BRIEF.md
# Self-Locking Write-Mask Trap Control Register

This block holds two 64-bit registers. The first is a trap-control register that is split into seven named fields. The second is a write-mask register with one protect bit for each field. When a control write is accepted, it changes only the fields whose protect bit is clear. Fields whose protect bit is set keep their old value. Bits outside the seven fields are reserved and stay zero in both registers.

The mask register locks itself at the hypervisor level. A level-2 write to the mask is refused while the effective mask is nonzero. A level-3 write always lands, and it is the only way to release a mask that has already been set. When the hypervisor level is disabled in the current security state, the effective mask is zero. In that state every field is writable and the mask can be written again from level 2.

Software drives a single-cycle request port. Each request carries a write flag, a register select, the current privilege level and the write data. The response comes one cycle later with an outcome code and the read data.

Top module: `trap_wmask_regs`

## Requirements
- R1: A synchronous reset clears both registers and the response valid flag.
- R2: A control write that is accepted updates only the unprotected fields. A set protect bit holds its whole field, including both bits of a 2-bit field. The fields and their protect bits are as follows:
  - bit 31, protected by mask bit 31
  - bit 30, protected by mask bit 30
  - bit 29, protected by mask bit 29
  - bit 28, protected by mask bit 28
  - bits 25:24, protected by mask bit 24
  - bits 21:20, protected by mask bit 20
  - bits 17:16, protected by mask bit 16
- R3: Control bits outside the fields in R2 always read as zero.
- R4: The only implemented mask bits are 31, 30, 29, 28, 24, 20 and 16. Every other mask bit reads as zero and ignores writes.
- R5: A level-2 mask write while the effective mask is nonzero returns UNDEF (code 2'b01) and changes nothing.
- R6: A level-3 mask write always stores the write data, restricted to the implemented bits, whatever the mask holds.
- R7: Any access at level 0, and any mask access at level 1, returns UNDEF and changes nothing. Control accesses at levels 1 to 3 return OK (code 2'b00).
- R8: With the hypervisor level disabled (hyp_en=0), the effective mask is zero. Every field is then writable, and a level-2 mask write is accepted.
- R9: rsp_valid follows req_valid one cycle later. rsp_rdata carries the register value from before the request for an accepted read. It is zero for writes and for UNDEF outcomes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = control register, 1 = mask register |
| req_level | input | 2 | Current privilege level, 0 to 3 |
| req_wdata | input | 64 | Write data |
| hyp_en | input | 1 | Hypervisor level enabled in current security state |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 2'b00 OK, 2'b01 UNDEF |
| rsp_rdata | output | 64 | Read data |

## Verification
Random control writes run against random mask contents, with the hypervisor level both on and off. Together they separate three cases: field-level protection, gating of single bits only, and a mask that is applied even when it should be ignored. Directed cases set one protect bit at a time with all-ones and all-zeros data, which shows whether both bits of each 2-bit field follow their single protect bit. Mask writes are attempted from every level while the mask is zero and while it is nonzero. These show the self-lock at level 2 separately from the level-3 override, and the refusals at levels 0 and 1. All-ones writes show that reserved bits stay zero.

// File: rtl/trap_wmask_pkg.sv
package trap_wmask_pkg;

  localparam int DW     = 64;
  localparam int LVL_W  = 2;
  localparam int NF     = 7;
  localparam int FW_MAX = 2;

  // Protect-bit position (also field base) and field width
  localparam int FPOS [NF] = '{31, 30, 29, 28, 24, 20, 16};
  localparam int FWID [NF] = '{1, 1, 1, 1, 2, 2, 2};

  typedef enum logic [1:0] {
    RSP_OK    = 2'b00,
    RSP_UNDEF = 2'b01
  } rsp_code_e;

  localparam logic [LVL_W-1:0] LVL_USER = 2'd0;
  localparam logic [LVL_W-1:0] LVL_KERN = 2'd1;
  localparam logic [LVL_W-1:0] LVL_HYP  = 2'd2;
  localparam logic [LVL_W-1:0] LVL_MON  = 2'd3;

  function automatic logic [DW-1:0] calc_mask_legal();
    logic [DW-1:0] r;
    r = '0;
    for (int f = 0; f < NF; f++) r[FPOS[f]] = 1'b1;
    return r;
  endfunction

  function automatic logic [DW-1:0] expand_protect(input logic [DW-1:0] m);
    logic [DW-1:0] r;
    r = '0;
    for (int f = 0; f < NF; f++)
      for (int b = 0; b < FW_MAX; b++)
        if (b < FWID[f] && m[FPOS[f]]) r[FPOS[f]+b] = 1'b1;
    return r;
  endfunction

  localparam logic [DW-1:0] MASK_LEGAL = calc_mask_legal();
  localparam logic [DW-1:0] CTRL_LEGAL = expand_protect(MASK_LEGAL);

endpackage

// File: rtl/wm_access_decode.sv
module wm_access_decode
  import trap_wmask_pkg::*;
#(
  parameter int W  = DW,
  parameter int LW = LVL_W
) (
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_sel,
  input  logic [LW-1:0] req_level,
  input  logic          hyp_en,
  input  logic [W-1:0]  mask_q,
  output logic [W-1:0]  eff_mask,
  output logic          undef,
  output logic          ctrl_we,
  output logic          mask_we
);

  logic mask_locked;

  always_comb begin
    eff_mask    = hyp_en ? mask_q : '0;
    mask_locked = (eff_mask != '0);
    undef       = 1'b0;
    if (req_level == LVL_USER) begin
      undef = 1'b1;
    end else if (req_sel) begin
      if (req_level == LVL_KERN)
        undef = 1'b1;
      else if (req_level == LVL_HYP && req_write && mask_locked)
        undef = 1'b1;
    end
    ctrl_we = req_valid && req_write && !req_sel && !undef;
    mask_we = req_valid && req_write &&  req_sel && !undef;
  end

endmodule

// File: rtl/wm_mask_reg.sv
module wm_mask_reg
  import trap_wmask_pkg::*;
#(
  parameter int W = DW,
  parameter logic [W-1:0] LEGAL = MASK_LEGAL
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (rst)     mask_q <= '0;
    else if (we) mask_q <= wdata & LEGAL;
  end

endmodule

// File: rtl/wm_ctrl_reg.sv
module wm_ctrl_reg
  import trap_wmask_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] eff_mask,
  output logic [W-1:0] ctrl_q
);

  localparam logic [W-1:0] LEGAL = CTRL_LEGAL;

  // One register slice per field, gated by its own protect bit
  for (genvar f = 0; f < NF; f++) begin : g_field
    localparam int P  = FPOS[f];
    localparam int FW = FWID[f];
    logic [FW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                     q <= '0;
      else if (we && !eff_mask[P]) q <= wdata[P +: FW];
    end
    assign ctrl_q[P +: FW] = q;
  end

  // Reserved bits tie to zero
  for (genvar b = 0; b < W; b++) begin : g_resv
    if (!LEGAL[b]) begin : g_zero
      assign ctrl_q[b] = 1'b0;
    end
  end

endmodule

// File: rtl/trap_wmask_regs.sv
module trap_wmask_regs
  import trap_wmask_pkg::*;
#(
  parameter int W  = DW,
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_sel,
  input  logic [LW-1:0] req_level,
  input  logic [W-1:0]  req_wdata,
  input  logic          hyp_en,
  output logic          rsp_valid,
  output logic [1:0]    rsp_code,
  output logic [W-1:0]  rsp_rdata
);

  logic [W-1:0] mask_q, ctrl_q, eff_mask;
  logic         undef, ctrl_we, mask_we;

  wm_access_decode #(.W(W), .LW(LW)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel),
    .req_level(req_level), .hyp_en(hyp_en), .mask_q(mask_q),
    .eff_mask(eff_mask), .undef(undef), .ctrl_we(ctrl_we), .mask_we(mask_we)
  );

  wm_mask_reg #(.W(W)) u_mask (
    .clk(clk), .rst(rst), .we(mask_we), .wdata(req_wdata), .mask_q(mask_q)
  );

  wm_ctrl_reg #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .we(ctrl_we), .wdata(req_wdata),
    .eff_mask(eff_mask), .ctrl_q(ctrl_q)
  );

  // Registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_OK;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_code  <= (req_valid && undef) ? RSP_UNDEF : RSP_OK;
      if (req_valid && !req_write && !undef)
        rsp_rdata <= req_sel ? mask_q : ctrl_q;
      else
        rsp_rdata <= '0;
    end
  end

endmodule

// File: rtl/trap_wmask_chk.sv
module trap_wmask_chk
  import trap_wmask_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_sel,
  input logic [LVL_W-1:0]  req_level,
  input logic [DW-1:0]     req_wdata,
  input logic              hyp_en,
  input logic              rsp_valid,
  input logic [1:0]        rsp_code,
  input logic [DW-1:0]     ctrl_q,
  input logic [DW-1:0]     mask_q
);

  logic [DW-1:0] prot_now;
  assign prot_now = hyp_en ? expand_protect(mask_q) : '0;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (ctrl_q == '0 && mask_q == '0 && !rsp_valid));

  p_protected_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !req_sel)
      |=> (((ctrl_q ^ $past(ctrl_q)) & $past(prot_now)) == '0));

  p_ctrl_resv_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & ~CTRL_LEGAL) == '0);

  p_mask_resv_r4: assert property (@(posedge clk) disable iff (rst)
    (mask_q & ~MASK_LEGAL) == '0);

  p_self_lock_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_sel && req_level == LVL_HYP && hyp_en && mask_q != '0)
      |=> (rsp_code == RSP_UNDEF && mask_q == $past(mask_q)));

  p_mon_write_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_sel && req_level == LVL_MON)
      |=> (rsp_code == RSP_OK && mask_q == ($past(req_wdata) & MASK_LEGAL)));

  p_user_undef_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_level == LVL_USER)
      |=> (rsp_code == RSP_UNDEF && $stable(ctrl_q) && $stable(mask_q)));

  p_hyp_off_free_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !req_sel && req_level != LVL_USER && !hyp_en)
      |=> (ctrl_q == ($past(req_wdata) & CTRL_LEGAL)));

  p_rsp_follow_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_rsp_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

endmodule

bind trap_wmask_regs trap_wmask_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_sel(req_sel), .req_level(req_level), .req_wdata(req_wdata),
  .hyp_en(hyp_en), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .ctrl_q(ctrl_q), .mask_q(mask_q)
);

// File: tb/sim_trap_wmask_regs.sv
`timescale 1ns/1ps
module sim_trap_wmask_regs;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_sel, hyp_en;
  logic [1:0]  req_level;
  logic [63:0] req_wdata;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [63:0] rsp_rdata;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [63:0] B_CTRL = 64'h0000_0000_F333_0000;
  localparam logic [63:0] B_MASK = 64'h0000_0000_F111_0000;

  logic [63:0] m_ctrl, m_mask;

  always #4 clk = ~clk;  // 125 MHz

  trap_wmask_regs u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_level(req_level), .req_wdata(req_wdata),
    .hyp_en(hyp_en), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_rdata(rsp_rdata)
  );

  function automatic logic [63:0] prot_of(input logic [63:0] m);
    logic [63:0] r = '0;
    r[31] = m[31]; r[30] = m[30]; r[29] = m[29]; r[28] = m[28];
    r[25:24] = {2{m[24]}};
    r[21:20] = {2{m[20]}};
    r[17:16] = {2{m[16]}};
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One request, compare response against the model, then update the model
  task automatic access(input string tag, input bit wr, input bit sel,
                        input logic [1:0] lvl, input bit hyp, input logic [63:0] d);
    logic [63:0] eff, pr, exp_rd;
    bit und;
    eff = hyp ? m_mask : 64'h0;
    und = (lvl == 2'd0) || (sel && lvl == 2'd1) ||
          (sel && wr && lvl == 2'd2 && eff != 64'h0);
    exp_rd = (!und && !wr) ? (sel ? m_mask : m_ctrl) : 64'h0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_sel = sel;
    req_level = lvl; hyp_en = hyp; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid R9"}, {63'h0, rsp_valid}, 64'h1);
    check({tag, " code R7"}, {62'h0, rsp_code}, und ? 64'h1 : 64'h0);
    check({tag, " rdata R9"}, rsp_rdata, exp_rd);
    if (!und && wr) begin
      if (sel) m_mask = d & B_MASK;
      else begin
        pr = prot_of(eff);
        m_ctrl = (m_ctrl & pr) | (d & B_CTRL & ~pr);
      end
    end
  endtask

  task automatic readback(input string tag);
    access({tag, " rbC"}, 1'b0, 1'b0, 2'd3, 1'b1, 64'h0);
    access({tag, " rbM"}, 1'b0, 1'b1, 2'd3, 1'b1, 64'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    logic [63:0] d;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_sel = 1'b0;
    req_level = 2'd0; hyp_en = 1'b1; req_wdata = '0;
    m_ctrl = '0; m_mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("reset rsp_valid R1", {63'h0, rsp_valid}, 64'h0);
    readback("R1 reset");

    // R3, R4: all-ones writes leave reserved bits zero
    access("R3 ctrl ones", 1'b1, 1'b0, 2'd2, 1'b1, '1);
    access("R4 mask ones", 1'b1, 1'b1, 2'd2, 1'b1, '1);
    readback("R3 R4");
    access("R6 clear", 1'b1, 1'b1, 2'd3, 1'b1, 64'h0);

    // R2: one protect bit at a time
    for (int f = 0; f < 7; f++) begin
      int pos;
      pos = (f < 4) ? 31 - f : 24 - 4 * (f - 4);
      access("R2 ctl zero", 1'b1, 1'b0, 2'd2, 1'b1, 64'h0);
      access("R6 set one", 1'b1, 1'b1, 2'd3, 1'b1, 64'h1 << pos);
      access("R2 ctl ones", 1'b1, 1'b0, 2'd1, 1'b1, '1);
      readback("R2 field");
      access("R5 lock", 1'b1, 1'b1, 2'd2, 1'b1, 64'h0);
      access("R8 hyp off", 1'b1, 1'b0, 2'd2, 1'b0, '1);
      readback("R8 field");
      access("R6 clear", 1'b1, 1'b1, 2'd3, 1'b1, 64'h0);
    end

    // R7: lower levels refused
    access("R7 user ctl wr", 1'b1, 1'b0, 2'd0, 1'b1, 64'hA5A5);
    access("R7 user msk rd", 1'b0, 1'b1, 2'd0, 1'b1, 64'h0);
    access("R7 kern msk wr", 1'b1, 1'b1, 2'd1, 1'b1, '1);
    // R8: hypervisor off unlocks level-2 mask write
    access("R6 set", 1'b1, 1'b1, 2'd3, 1'b1, 64'hF111_0000);
    access("R8 unlock", 1'b1, 1'b1, 2'd2, 1'b0, 64'h0001_0000);
    readback("R8 mask");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      d = {$urandom, $urandom};
      if ($urandom % 8 == 0) d[31:16] = 16'h0000;
      access("R2 R5 rnd", 1'($urandom), 1'($urandom), 2'($urandom), ($urandom % 4) != 0, d);
      if (i % 50 == 49) readback("R2 rnd");
    end
    readback("final");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule